// File: doc/BRIEF.md
# Task Register Load Checker

This block sits beside an instruction sequencer and handles the load of the task register. The sequencer has already looked up the descriptor, so it hands over the selector together with the decoded descriptor fields: local-table flag, non-system flag, type, limit, base and present. The block screens that pair against the protection rules and reports the outcome. A bad pair raises exactly one of three fault pulses, carrying the selector index as its error code. A good pair is committed into the task register outputs.

On commit the block also pulses a request to mark the descriptor busy. For a 32-bit task segment it reads one 16-bit word through a simple read port: the offset of the I/O permission bitmap, located 102 bytes into the segment. From that offset it derives the window of the bitmap (its address and length) that later port-access checks use. A 16-bit task segment has no bitmap, so its window is empty. Table lookup and the busy-bit write to memory belong to the surrounding logic.

Top module: `task_reg_load_check`

## Requirements
- R1: When the captured selector has its local-table flag set, or the descriptor has its non-system flag set, the block raises `fault_gp`. The `fault_code` output then holds selector bits [15:3].
- R2: A type-1 descriptor (available 16-bit task segment) whose limit is below 0x2B raises `fault_ts`. A type-9 descriptor (available 32-bit task segment) whose limit is below 0x67 raises `fault_ts`. In both cases `fault_code` holds selector bits [15:3].
- R3: Any type other than 1 or 9, on an otherwise acceptable selector, raises `fault_gp`.
- R4: A descriptor that passes the R1 to R3 checks but has `req_present` low raises `fault_np`.
- R5: Only one outcome is reported per request, chosen in the order R1, then R2/R3, then R4. `done`, `fault_gp`, `fault_ts` and `fault_np` are each one-cycle pulses, and at most one of them is high in any cycle.
- R6: A type-9 descriptor that passes every check causes a read at address base + 102. `mem_rd_valid` stays high with a stable address until `mem_rd_ready` is seen. A type-1 descriptor and any faulting request issue no read.
- R7: On commit, `done` and `set_busy` pulse together. `tr_sel`, `tr_base` and `tr_limit` take the request's values, and `tr_type` takes the request type with bit 1 set (1 becomes 3, 9 becomes 0xB).
- R8: On a 32-bit commit with a returned offset that is nonzero and below the limit, `io_limit` becomes the low 16 bits of (limit − offset) and `io_addr` becomes base + offset. Otherwise `io_limit` becomes 0 and `io_addr` keeps its value.
- R9: A 16-bit commit sets `io_limit` to 0.
- R10: `req_ready` is low from acceptance until the outcome. A `req_valid` seen while `req_ready` is low is ignored.
- R11: A faulting request leaves `tr_sel`, `tr_base`, `tr_limit`, `tr_type`, `io_addr` and `io_limit` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_sel | input | 16 | Selector to load |
| req_local | input | 1 | Selector refers to the local table |
| req_nonsys | input | 1 | Descriptor is a code/data (non-system) descriptor |
| req_type | input | 4 | Descriptor type field |
| req_limit | input | LIMIT_W | Segment limit |
| req_base | input | ADDR_W | Segment base |
| req_present | input | 1 | Descriptor present flag |
| mem_rd_valid | output | 1 | Read request for the bitmap offset word |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | ADDR_W | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | IO_W | Returned word |
| done | output | 1 | Commit pulse |
| set_busy | output | 1 | Pulse: mark the loaded descriptor busy |
| fault_gp | output | 1 | General-protection fault pulse |
| fault_ts | output | 1 | Invalid-task-segment fault pulse |
| fault_np | output | 1 | Not-present fault pulse |
| fault_code | output | 13 | Selector index of the faulting request |
| tr_sel | output | 16 | Loaded task register selector |
| tr_base | output | ADDR_W | Loaded segment base |
| tr_limit | output | LIMIT_W | Loaded segment limit |
| tr_type | output | 4 | Loaded type, busy bit set |
| io_addr | output | ADDR_W | Start address of the I/O bitmap window |
| io_limit | output | IO_W | Length of the I/O bitmap window, 0 for none |

## Verification
The assertions cover the properties that hold in every cycle:
- the outcome pulses are mutually exclusive and last one cycle;
- the read request holds steady until it is accepted;
- no request is taken while a read is outstanding;
- a commit always carries a busy type and the busy pulse;
- a fault never moves the task register;
- a window never runs past the limit, and a 16-bit load never leaves one open.

The bench scenarios are what show the threshold values (0x2A against 0x2B, 0x66 against 0x67), the fault priority when several conditions fail at once, and the exact read address. They also show the window arithmetic when the offset is zero, equal to the limit or one below it, or when the difference overflows 16 bits, and that a request arriving mid-read is dropped.

// File: rtl/trl_pkg.sv
package trl_pkg;

   typedef enum logic [1:0] {
      VERDICT_OK = 2'd0,
      VERDICT_GP = 2'd1,
      VERDICT_TS = 2'd2,
      VERDICT_NP = 2'd3
   } trl_verdict_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_READ  = 2'd2,
      ST_WAIT  = 2'd3
   } trl_state_e;

   localparam logic [3:0] TYPE_AVAIL16 = 4'h1;
   localparam logic [3:0] TYPE_AVAIL32 = 4'h9;
   localparam int         BUSY_BIT     = 1;
   localparam int         SEL_W        = 16;
   localparam int         IDX_W        = SEL_W - 3;

endpackage

// File: rtl/trl_desc_classify.sv
module trl_desc_classify
   import trl_pkg::*;
#(
   parameter int LIMIT_W = 32,
   parameter int MIN16   = 'h2B,
   parameter int MIN32   = 'h67
) (
   input  logic               is_local,
   input  logic               is_nonsys,
   input  logic [3:0]         dtype,
   input  logic [LIMIT_W-1:0] limit,
   input  logic               present,
   output trl_verdict_e       verdict,
   output logic               is32
);

   localparam logic [LIMIT_W-1:0] MIN16_L = LIMIT_W'(MIN16);
   localparam logic [LIMIT_W-1:0] MIN32_L = LIMIT_W'(MIN32);

   if (MIN16 <= 0 || MIN32 <= 0) begin : g_bad_min
      $error("trl_desc_classify: minimum limits must be positive");
   end

   logic sel_bad;
   logic type_bad;
   logic lim_bad;

   always_comb begin
      sel_bad  = is_local | is_nonsys;
      type_bad = (dtype != TYPE_AVAIL16) && (dtype != TYPE_AVAIL32);
      lim_bad  = (dtype == TYPE_AVAIL16) ? (limit < MIN16_L) : (limit < MIN32_L);
      is32     = (dtype == TYPE_AVAIL32);
      if (sel_bad)       verdict = VERDICT_GP;
      else if (type_bad) verdict = VERDICT_GP;
      else if (lim_bad)  verdict = VERDICT_TS;
      else if (!present) verdict = VERDICT_NP;
      else               verdict = VERDICT_OK;
   end

endmodule

// File: rtl/trl_io_window.sv
module trl_io_window #(
   parameter int ADDR_W  = 32,
   parameter int LIMIT_W = 32,
   parameter int IO_W    = 16
) (
   input  logic [ADDR_W-1:0]  base,
   input  logic [LIMIT_W-1:0] limit,
   input  logic [IO_W-1:0]    offset,
   output logic               hit,
   output logic [ADDR_W-1:0]  win_addr,
   output logic [IO_W-1:0]    win_len
);

   if (IO_W > LIMIT_W || IO_W > ADDR_W) begin : g_bad_w
      $error("trl_io_window: offset wider than limit or address");
   end

   logic [LIMIT_W-1:0] off_ext;
   logic [LIMIT_W-1:0] diff;

   always_comb begin
      off_ext  = LIMIT_W'(offset);
      diff     = limit - off_ext;
      hit      = (offset != '0) && (off_ext < limit);
      win_addr = base + ADDR_W'(offset);
   end

   if (LIMIT_W > IO_W) begin : g_trunc
      assign win_len = diff[IO_W-1:0];
   end else begin : g_same
      assign win_len = diff;
   end

endmodule

// File: rtl/task_reg_load_check.sv
module task_reg_load_check
   import trl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIMIT_W    = 32,
   parameter int IO_W       = 16,
   parameter int IOBASE_OFS = 102,
   parameter int MIN16      = 'h2B,
   parameter int MIN32      = 'h67
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [15:0]        req_sel,
   input  logic               req_local,
   input  logic               req_nonsys,
   input  logic [3:0]         req_type,
   input  logic [LIMIT_W-1:0] req_limit,
   input  logic [ADDR_W-1:0]  req_base,
   input  logic               req_present,
   output logic               mem_rd_valid,
   input  logic               mem_rd_ready,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rsp_valid,
   input  logic [IO_W-1:0]    mem_rsp_data,
   output logic               done,
   output logic               set_busy,
   output logic               fault_gp,
   output logic               fault_ts,
   output logic               fault_np,
   output logic [12:0]        fault_code,
   output logic [15:0]        tr_sel,
   output logic [ADDR_W-1:0]  tr_base,
   output logic [LIMIT_W-1:0] tr_limit,
   output logic [3:0]         tr_type,
   output logic [ADDR_W-1:0]  io_addr,
   output logic [IO_W-1:0]    io_limit
);

   localparam logic [ADDR_W-1:0] OFS_A    = ADDR_W'(IOBASE_OFS);
   localparam logic [3:0]        BUSY_SET = 4'(1 << BUSY_BIT);

   if (ADDR_W < 16 || LIMIT_W < 16) begin : g_bad_w
      $error("task_reg_load_check: address and limit need at least 16 bits");
   end
   if (IOBASE_OFS < 0) begin : g_bad_ofs
      $error("task_reg_load_check: offset location must be non-negative");
   end

   trl_state_e         state;
   logic [15:0]        c_sel;
   logic               c_local;
   logic               c_nonsys;
   logic [3:0]         c_type;
   logic [LIMIT_W-1:0] c_limit;
   logic [ADDR_W-1:0]  c_base;
   logic               c_present;

   trl_verdict_e       verdict;
   logic               is32;
   logic               win_hit;
   logic [ADDR_W-1:0]  win_addr;
   logic [IO_W-1:0]    win_len;

   trl_desc_classify #(
      .LIMIT_W (LIMIT_W),
      .MIN16   (MIN16),
      .MIN32   (MIN32)
   ) u_classify (
      .is_local  (c_local),
      .is_nonsys (c_nonsys),
      .dtype     (c_type),
      .limit     (c_limit),
      .present   (c_present),
      .verdict   (verdict),
      .is32      (is32)
   );

   trl_io_window #(
      .ADDR_W  (ADDR_W),
      .LIMIT_W (LIMIT_W),
      .IO_W    (IO_W)
   ) u_window (
      .base     (c_base),
      .limit    (c_limit),
      .offset   (mem_rsp_data),
      .hit      (win_hit),
      .win_addr (win_addr),
      .win_len  (win_len)
   );

   assign req_ready    = (state == ST_IDLE);
   assign mem_rd_valid = (state == ST_READ);
   assign mem_rd_addr  = c_base + OFS_A;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         c_sel      <= '0;
         c_local    <= 1'b0;
         c_nonsys   <= 1'b0;
         c_type     <= '0;
         c_limit    <= '0;
         c_base     <= '0;
         c_present  <= 1'b0;
         done       <= 1'b0;
         set_busy   <= 1'b0;
         fault_gp   <= 1'b0;
         fault_ts   <= 1'b0;
         fault_np   <= 1'b0;
         fault_code <= '0;
         tr_sel     <= '0;
         tr_base    <= '0;
         tr_limit   <= '0;
         tr_type    <= '0;
         io_addr    <= '0;
         io_limit   <= '0;
      end else begin
         done     <= 1'b0;
         set_busy <= 1'b0;
         fault_gp <= 1'b0;
         fault_ts <= 1'b0;
         fault_np <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  c_sel     <= req_sel;
                  c_local   <= req_local;
                  c_nonsys  <= req_nonsys;
                  c_type    <= req_type;
                  c_limit   <= req_limit;
                  c_base    <= req_base;
                  c_present <= req_present;
                  state     <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               fault_code <= c_sel[15:3];
               unique case (verdict)
                  VERDICT_GP: begin fault_gp <= 1'b1; state <= ST_IDLE; end
                  VERDICT_TS: begin fault_ts <= 1'b1; state <= ST_IDLE; end
                  VERDICT_NP: begin fault_np <= 1'b1; state <= ST_IDLE; end
                  default: begin
                     if (is32) begin
                        state <= ST_READ;
                     end else begin
                        done     <= 1'b1;
                        set_busy <= 1'b1;
                        tr_sel   <= c_sel;
                        tr_base  <= c_base;
                        tr_limit <= c_limit;
                        tr_type  <= c_type | BUSY_SET;
                        io_limit <= '0;
                        state    <= ST_IDLE;
                     end
                  end
               endcase
            end
            ST_READ: begin
               if (mem_rd_ready) state <= ST_WAIT;
            end
            default: begin
               if (mem_rsp_valid) begin
                  done     <= 1'b1;
                  set_busy <= 1'b1;
                  tr_sel   <= c_sel;
                  tr_base  <= c_base;
                  tr_limit <= c_limit;
                  tr_type  <= c_type | BUSY_SET;
                  if (win_hit) begin
                     io_addr  <= win_addr;
                     io_limit <= win_len;
                  end else begin
                     io_limit <= '0;
                  end
                  state <= ST_IDLE;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/task_reg_load_check_sva.sv
module task_reg_load_check_sva #(
   parameter int ADDR_W  = 32,
   parameter int LIMIT_W = 32,
   parameter int IO_W    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               mem_rd_valid,
   input logic               mem_rd_ready,
   input logic [ADDR_W-1:0]  mem_rd_addr,
   input logic               done,
   input logic               set_busy,
   input logic               fault_gp,
   input logic               fault_ts,
   input logic               fault_np,
   input logic [15:0]        tr_sel,
   input logic [LIMIT_W-1:0] tr_limit,
   input logic [3:0]         tr_type,
   input logic [IO_W-1:0]    io_limit
);

   logic any_fault;
   assign any_fault = fault_gp | fault_ts | fault_np;

   assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fault_gp, fault_ts, fault_np}));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      any_fault |=> !any_fault);

   assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   assert_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);

   assert_busy_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tr_type[1] && set_busy));

   assert_fault_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
      any_fault |-> ($stable(tr_sel) && $stable(tr_type) && $stable(io_limit)));

   assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (LIMIT_W'(io_limit) <= tr_limit));

   assert_no_window16_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tr_type == 4'h3) |-> (io_limit == '0));

endmodule

bind task_reg_load_check task_reg_load_check_sva #(
   .ADDR_W  (ADDR_W),
   .LIMIT_W (LIMIT_W),
   .IO_W    (IO_W)
) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .mem_rd_valid (mem_rd_valid),
   .mem_rd_ready (mem_rd_ready),
   .mem_rd_addr  (mem_rd_addr),
   .done         (done),
   .set_busy     (set_busy),
   .fault_gp     (fault_gp),
   .fault_ts     (fault_ts),
   .fault_np     (fault_np),
   .tr_sel       (tr_sel),
   .tr_limit     (tr_limit),
   .tr_type      (tr_type),
   .io_limit     (io_limit)
);

// File: tb/task_reg_load_check_bench.sv
`timescale 1ns/1ps
module task_reg_load_check_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_sel = '0;
   logic        req_local = 1'b0;
   logic        req_nonsys = 1'b0;
   logic [3:0]  req_type = '0;
   logic [31:0] req_limit = '0;
   logic [31:0] req_base = '0;
   logic        req_present = 1'b0;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [15:0] mem_rsp_data = '0;
   logic        done, set_busy, fault_gp, fault_ts, fault_np;
   logic [12:0] fault_code;
   logic [15:0] tr_sel;
   logic [31:0] tr_base, tr_limit, io_addr;
   logic [3:0]  tr_type;
   logic [15:0] io_limit;

   int n_checks = 0;
   int n_err    = 0;

   // model state
   logic [15:0] m_sel = '0;
   logic [31:0] m_base = '0, m_limit = '0, m_io_addr = '0;
   logic [3:0]  m_type = '0;
   logic [15:0] m_io_limit = '0;

   always #2.5 clk = ~clk;

   task_reg_load_check u_task_reg_load_check (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_sel(req_sel), .req_local(req_local), .req_nonsys(req_nonsys),
      .req_type(req_type), .req_limit(req_limit), .req_base(req_base),
      .req_present(req_present), .mem_rd_valid(mem_rd_valid),
      .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .set_busy(set_busy), .fault_gp(fault_gp),
      .fault_ts(fault_ts), .fault_np(fault_np), .fault_code(fault_code),
      .tr_sel(tr_sel), .tr_base(tr_base), .tr_limit(tr_limit),
      .tr_type(tr_type), .io_addr(io_addr), .io_limit(io_limit)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // 0 commit, 1 gp, 2 ts, 3 np
   function automatic int exp_verdict(bit loc, bit ns, logic [3:0] ty,
                                      logic [31:0] lim, bit pr);
      if (loc || ns) return 1;
      if (ty == 4'h1) begin
         if (lim < 32'h2B) return 2;
      end else if (ty == 4'h9) begin
         if (lim < 32'h67) return 2;
      end else return 1;
      if (!pr) return 3;
      return 0;
   endfunction

   task automatic run_one(input logic [15:0] sel, input bit loc, input bit ns,
                          input logic [3:0] ty, input logic [31:0] lim,
                          input logic [31:0] base, input bit pr,
                          input logic [15:0] iob, input bit poke);
      int          ev;
      int          got;
      bit          fin = 0, got_req = 0, saw_rd = 0, poked = 0;
      int          rsp_cnt = -1;
      logic [31:0] seen_addr = '0;
      logic [12:0] seen_code = '0;
      bit          seen_busy = 0;
      ev = exp_verdict(loc, ns, ty, lim, pr);
      @(negedge clk);
      req_valid = 1; req_sel = sel; req_local = loc; req_nonsys = ns;
      req_type = ty; req_limit = lim; req_base = base; req_present = pr;
      @(negedge clk);
      req_valid = 0;
      got = -1;
      for (int c = 0; c < 60 && !fin; c++) begin
         @(negedge clk);
         mem_rsp_valid = 0;
         if (poked) req_valid = 0;
         if (mem_rd_valid) saw_rd = 1;
         if (done | fault_gp | fault_ts | fault_np) begin
            got = done ? 0 : fault_gp ? 1 : fault_ts ? 2 : 3;
            seen_code = fault_code;
            seen_busy = set_busy;
            fin = 1;
         end else if (mem_rd_ready) begin
            mem_rd_ready = 0; got_req = 1; rsp_cnt = int'($urandom % 3);
         end else if (mem_rd_valid && !got_req) begin
            if ($urandom % 2 == 0) begin mem_rd_ready = 1; seen_addr = mem_rd_addr; end
         end else if (got_req && rsp_cnt >= 0) begin
            if (poke && !poked) begin
               req_valid = 1; req_sel = 16'hFFF8; req_type = 4'h1; poked = 1;
            end
            if (rsp_cnt == 0) begin
               mem_rsp_valid = 1; mem_rsp_data = iob; rsp_cnt = -1;
            end else rsp_cnt--;
         end
      end
      req_valid = 0; mem_rsp_valid = 0; mem_rd_ready = 0;
      chk(got == ev, (ev == 3) ? "R4" : (ev == 2) ? "R2" : (ev == 1) ? "R1/R3 R5" : "R7",
          "outcome", got, ev);
      if (ev != 0) begin
         chk(seen_code == sel[15:3], "R1", "fault_code", seen_code, sel[15:3]);
         chk(!saw_rd, "R6", "no read on fault", saw_rd, 0);
         chk(tr_sel == m_sel && tr_type == m_type && tr_base == m_base &&
             tr_limit == m_limit, "R11", "tr kept", tr_sel, m_sel);
         chk(io_limit == m_io_limit && io_addr == m_io_addr, "R11", "io kept",
             io_limit, m_io_limit);
      end else begin
         m_sel = sel; m_base = base; m_limit = lim; m_type = ty | 4'h2;
         if (ty == 4'h9) begin
            chk(got_req && seen_addr == base + 32'd102, "R6", "read address",
                seen_addr, base + 32'd102);
            if (iob != 0 && {16'h0, iob} < lim) begin
               m_io_limit = 16'(lim - {16'h0, iob});
               m_io_addr  = base + {16'h0, iob};
            end else m_io_limit = 0;
            chk(io_limit == m_io_limit, "R8", "io_limit", io_limit, m_io_limit);
            chk(io_addr == m_io_addr, "R8", "io_addr", io_addr, m_io_addr);
         end else begin
            chk(!saw_rd, "R6", "no read for 16-bit", saw_rd, 0);
            m_io_limit = 0;
            chk(io_limit == 0, "R9", "io_limit", io_limit, 0);
         end
         chk(seen_busy, "R7", "set_busy", seen_busy, 1);
         chk(tr_sel == m_sel, poke ? "R10" : "R7", "tr_sel", tr_sel, m_sel);
         chk(tr_type == m_type, "R7", "tr_type", tr_type, m_type);
         chk(tr_base == m_base && tr_limit == m_limit, "R7", "tr base/limit",
             tr_base, m_base);
      end
      @(negedge clk);
      chk(!(done | fault_gp | fault_ts | fault_np), "R5", "single pulse", done, 0);
      chk(req_ready, "R10", "ready after outcome", req_ready, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++; n_checks++;
      $display("FAIL all watchdog: actual=0x0 expected=0x1");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      logic [3:0]  ty;
      logic [31:0] lim;
      logic [15:0] iob;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(!done && !fault_gp && !fault_ts && !fault_np && req_ready && io_limit == 0
          && tr_sel == 0, "R5", "reset state", done, 0);
      rst_n = 1;
      @(negedge clk);
      // directed corner cases
      run_one(16'h0048, 0, 0, 4'h1, 32'h2A, 32'h1000, 1, 0, 0);          // R2 16-bit below
      run_one(16'h0050, 0, 0, 4'h1, 32'h2B, 32'h2000, 1, 0, 0);          // R9 16-bit at min
      run_one(16'h0058, 0, 0, 4'h9, 32'h66, 32'h3000, 1, 0, 0);          // R2 32-bit below
      run_one(16'h0060, 0, 0, 4'h9, 32'h67, 32'h4000, 1, 16'h68, 0);     // R8 offset>limit
      run_one(16'h0068, 0, 0, 4'h9, 32'h2000, 32'h5000, 1, 16'h68, 0);   // R8 window
      run_one(16'h0070, 0, 0, 4'h9, 32'h2000, 32'h6000, 1, 16'h0, 0);    // R8 zero offset
      run_one(16'h0078, 0, 0, 4'h9, 32'h2000, 32'h7000, 1, 16'h2000, 0); // R8 equal
      run_one(16'h0080, 0, 0, 4'h9, 32'h2000, 32'h7100, 1, 16'h1FFF, 0); // R8 one below
      run_one(16'h0088, 0, 0, 4'h9, 32'h30000, 32'h7200, 1, 16'h10, 0);  // R8 truncation
      run_one(16'h0090, 1, 1, 4'h2, 32'h0, 32'h0, 0, 0, 0);              // R5 all bad -> GP
      run_one(16'h0098, 0, 1, 4'h9, 32'hFFFF, 32'h0, 1, 0, 0);           // R1 non-system
      run_one(16'h00A0, 0, 0, 4'hB, 32'hFFFF, 32'h0, 1, 0, 0);           // R3 busy type
      run_one(16'h00A8, 0, 0, 4'h9, 32'h10, 32'h0, 0, 0, 0);             // R5 TS before NP
      run_one(16'h00B0, 0, 0, 4'h9, 32'h100, 32'h0, 0, 0, 0);            // R4
      run_one(16'h00B8, 0, 0, 4'h9, 32'h800, 32'h8000, 1, 16'h80, 1);    // R10 poke
      // constrained random
      for (int i = 0; i < 400; i++) begin
         case ($urandom % 6)
            0, 1: ty = 4'h9;
            2:    ty = 4'h1;
            3:    ty = 4'h3;
            4:    ty = 4'hB;
            default: ty = 4'($urandom);
         endcase
         case ($urandom % 4)
            0: lim = 32'h28 + ($urandom % 8);
            1: lim = 32'h63 + ($urandom % 8);
            2: lim = $urandom % 32'h4000;
            default: lim = $urandom % 32'h100000;
         endcase
         case ($urandom % 5)
            0: iob = 0;
            1: iob = 16'(lim);
            2: iob = 16'(lim - 1);
            3: iob = 16'($urandom % 32'h100);
            default: iob = 16'($urandom);
         endcase
         run_one(16'($urandom), ($urandom % 10) == 0, ($urandom % 10) == 0, ty,
                 lim, $urandom, ($urandom % 8) != 0, iob, ($urandom % 8) == 0);
      end
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule